// File: doc/BRIEF.md
# Register-Programmed Serial Flash Transaction Engine

This block runs one serial-flash transaction at a time, laid out by software through a small set of 32-bit registers. A transaction is built from up to five phases that always run in the same order: an opcode byte, an address of up to four bytes, dummy bytes, outgoing data bytes and incoming data bytes. Each phase has its own byte count and its own bus width of one, two or four data lines. Any phase whose count is zero is left out. Software writes the layout, the opcode, the address and up to sixteen outgoing bytes. It then sets a launch bit and polls that bit until hardware clears it. Incoming bytes are then held in four read-back words.

The flash side uses SPI mode 0. The serial clock idles low, the engine changes outgoing data while the clock is low, and it samples incoming data on the rising edge. The clock half-period is a fixed number of system clocks. The four data lines are brought out as separate out, enable and in vectors so that the pad ring can build the tristate drivers. A select-hold bit in the control word keeps the chosen device selected after a transaction ends. Software can therefore send an opcode and address in one transaction and stream data in the following ones as a single flash operation.

The register port is a plain write strobe with an address. It has no back-pressure: a write takes effect at the clock edge where the strobe is high. Read data is registered and appears on the cycle after the address is presented. Reads have no side effects.

Top module: `fsx_flash_engine`

## Requirements
- R1: After reset, the layout word reads 0, the control word reads 0x0001_0000 (only the release bit set), every select line is high and the serial clock is low.
- R2: Writing a control word with bit 0 set while idle launches a transaction. Bit 0 reads 1 while the transaction runs and reads 0 once it has finished.
- R3: Phases run as opcode, address, dummy, write data, read data. The opcode phase runs only when layout bit 10 is set. Every other phase runs only when its count is nonzero: address count in bits [13:11] (capped at 4), write count in bits [20:16] and read count in bits [28:24] (both capped at 16), dummy count in bits [23:21].
- R4: Each phase takes its width code from the layout word: opcode [1:0], address [3:2], write data [5:4], dummy [7:6], read data [9:8]. Code 0 selects one line (out on io 0, in on io 1). Code 1 selects two lines (io[1:0], bit pairs with the higher bit on io 1). Codes 2 and 3 select four lines (io[3:0], nibbles with the higher bit on io 3). Bytes are sent most significant bit first, and a phase takes 8, 4 or 2 clocks per byte.
- R5: The address phase sends only the low N bytes of the address word (offset 0x14), most significant of those first. The opcode byte is bits [7:0] of the word at offset 0x10.
- R6: Data bytes pack little-endian. Byte k sits in bits [8(k mod 4)+7 : 8(k mod 4)] of word k/4. The write words are at 0x20 to 0x2C and the read words at 0x30 to 0x3C.
- R7: The serial clock idles low and has a high time and a low time of HALF_DIV system clocks each. Output data does not change while the clock is high.
- R8: Control bits [9:8] pick the one select line (active low) that is driven low during the transaction. No more than one select line is ever low.
- R9: Control bit 16 clear keeps the select asserted after the transaction ends. Bit 16 set releases it once the engine is idle.
- R10: Control bit 24 is set when a transaction finishes and is cleared by writing 1 to it. Bit 25 is a plain stored enable that reads back as written.
- R11: While a transaction runs, writes to the layout, opcode, address and write-data words and to the select and release fields are ignored.
- R12: A launch with every phase empty finishes without any serial clock edge and without asserting a select line.
- R13: During dummy bytes and read bytes all data lines are undriven (enable 0), and a dummy byte takes as many clocks as its width code gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid one cycle after bus_addr |
| sck | output | 1 | Serial clock, mode 0 |
| cs_n | output | NCS | Active-low device selects |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
A launch write takes effect one cycle after its strobe. The first rising serial edge follows HALF_DIV cycles later, and every later edge follows another HALF_DIV cycles. Bit 0 of the control word clears one cycle after the last falling edge, and the read words have been loaded on the same edge. Register reads return their value on the cycle after the address is presented. For this reason the bench drives the bus at falling system edges and reads bus_rdata one full cycle later. It captures the lines at every rising serial edge and changes its input data only after a falling serial edge. It compares results only after polling shows the launch bit clear, so no check depends on how many cycles a transaction lasts, except for the clock period check, which measures the time between two captured rising edges.

// File: rtl/fsx_pkg.sv
package fsx_pkg;
  localparam logic [7:0] A_CFG = 8'h08;
  localparam logic [7:0] A_CTL = 8'h0C;
  localparam logic [7:0] A_CMD = 8'h10;
  localparam logic [7:0] A_ADR = 8'h14;
  localparam logic [7:0] A_WD0 = 8'h20;
  localparam logic [7:0] A_RD0 = 8'h30;

  localparam logic [2:0] PH_CMD = 3'd0;
  localparam logic [2:0] PH_ADR = 3'd1;
  localparam logic [2:0] PH_DUM = 3'd2;
  localparam logic [2:0] PH_WR  = 3'd3;
  localparam logic [2:0] PH_RD  = 3'd4;
  localparam logic [2:0] PH_END = 3'd5;

  // lines driven for a width code
  function automatic logic [3:0] lane_mask(input logic [1:0] code);
    case (code)
      2'd0:    lane_mask = 4'b0001;
      2'd1:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // clocks per byte minus one
  function automatic logic [2:0] byte_clks_m1(input logic [1:0] code);
    case (code)
      2'd0:    byte_clks_m1 = 3'd7;
      2'd1:    byte_clks_m1 = 3'd3;
      default: byte_clks_m1 = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/fsx_regs.sv
module fsx_regs
  import fsx_pkg::*;
#(
  parameter int MAXB = 16,
  parameter int SELW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 fin,
  input  logic [8*MAXB-1:0]    rx_bytes,
  output logic [31:0]          cfg_q,
  output logic [7:0]           cmd_q,
  output logic [31:0]          adr_q,
  output logic [8*MAXB-1:0]    wbytes,
  output logic [SELW-1:0]      sel_q,
  output logic                 rel_q,
  output logic                 launch
);
  localparam int NW = MAXB / 4;

  logic [NW-1:0][31:0] wd_q;
  logic go_q, rdy_q, ie_q, launch_q;
  logic kick;

  assign kick   = bus_wr && (bus_addr == A_CTL) && bus_wdata[0] && !go_q;
  assign launch = launch_q;
  assign wbytes = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cmd_q    <= '0;
      adr_q    <= '0;
      wd_q     <= '0;
      sel_q    <= '0;
      rel_q    <= 1'b1;
      go_q     <= 1'b0;
      rdy_q    <= 1'b0;
      ie_q     <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      launch_q <= kick;
      if (fin) begin
        go_q  <= 1'b0;
        rdy_q <= 1'b1;
      end
      if (bus_wr) begin
        if (bus_addr == A_CFG && !go_q) cfg_q <= bus_wdata;
        if (bus_addr == A_CMD && !go_q) cmd_q <= bus_wdata[7:0];
        if (bus_addr == A_ADR && !go_q) adr_q <= bus_wdata;
        if (bus_addr == A_CTL) begin
          ie_q <= bus_wdata[25];
          if (bus_wdata[24]) rdy_q <= 1'b0;
          if (!go_q) begin
            sel_q <= bus_wdata[8 +: SELW];
            rel_q <= bus_wdata[16];
            if (bus_wdata[0]) go_q <= 1'b1;
          end
        end
        for (int w = 0; w < NW; w++)
          if (bus_addr == A_WD0 + 8'(4 * w) && !go_q) wd_q[w] <= bus_wdata;
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CFG: rd_mux = cfg_q;
      A_CMD: rd_mux = {24'd0, cmd_q};
      A_ADR: rd_mux = adr_q;
      A_CTL: begin
        rd_mux[0]           = go_q;
        rd_mux[8 +: SELW]   = sel_q;
        rd_mux[16]          = rel_q;
        rd_mux[24]          = rdy_q;
        rd_mux[25]          = ie_q;
      end
      default: rd_mux = '0;
    endcase
    for (int w = 0; w < NW; w++) begin
      if (bus_addr == A_WD0 + 8'(4 * w)) rd_mux = wd_q[w];
      if (bus_addr == A_RD0 + 8'(4 * w)) rd_mux = rx_bytes[32*w +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/fsx_seq.sv
module fsx_seq
  import fsx_pkg::*;
#(
  parameter int NCS      = 4,
  parameter int MAXB     = 16,
  parameter int HALF_DIV = 2,
  parameter int SELW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [31:0]       cfg,
  input  logic [7:0]        cmd,
  input  logic [31:0]       adr,
  input  logic [8*MAXB-1:0] wbytes,
  input  logic [SELW-1:0]   sel,
  input  logic              rel,
  input  logic [3:0]        io_in,
  output logic              sck,
  output logic [NCS-1:0]    cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              fin,
  output logic [8*MAXB-1:0] rx_bytes
);
  localparam int          CW      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] DIV_END = CW'(HALF_DIV - 1);
  localparam logic [4:0]  MAXC    = 5'(MAXB);

  logic [7:0][4:0] cnt;
  logic [7:0][1:0] lc;

  always_comb begin
    cnt = '0;
    lc  = '0;
    cnt[PH_CMD] = {4'd0, cfg[10]};
    cnt[PH_ADR] = (cfg[13:11] > 3'd4) ? 5'd4 : {2'd0, cfg[13:11]};
    cnt[PH_DUM] = {2'd0, cfg[23:21]};
    cnt[PH_WR]  = (cfg[20:16] > MAXC) ? MAXC : cfg[20:16];
    cnt[PH_RD]  = (cfg[28:24] > MAXC) ? MAXC : cfg[28:24];
    lc[PH_CMD]  = cfg[1:0];
    lc[PH_ADR]  = cfg[3:2];
    lc[PH_DUM]  = cfg[7:6];
    lc[PH_WR]   = cfg[5:4];
    lc[PH_RD]   = cfg[9:8];
  end

  function automatic logic [2:0] first_from(input logic [2:0] from,
                                            input logic [7:0][4:0] c);
    logic [2:0] r;
    r = PH_END;
    for (int k = 4; k >= 0; k--)
      if (3'(k) >= from && c[k] != 5'd0) r = 3'(k);
    return r;
  endfunction

  function automatic logic [7:0] byte_sel(input logic [2:0] p, input logic [4:0] idx);
    logic [4:0]  back;
    logic [31:0] sa;
    back = cnt[PH_ADR] - idx - 5'd1;
    sa   = adr >> {back, 3'b000};
    case (p)
      PH_CMD:  byte_sel = cmd;
      PH_ADR:  byte_sel = sa[7:0];
      PH_WR:   byte_sel = wbytes[{idx, 3'b000} +: 8];
      default: byte_sel = 8'h00;
    endcase
  endfunction

  logic            busy, cs_on;
  logic [2:0]      ph;
  logic [4:0]      bidx;
  logic [2:0]      left;
  logic [7:0]      sh, rx;
  logic [CW-1:0]   div;
  logic [SELW-1:0] cs_q;
  logic [2:0]      first_ph, after_ph;
  logic [1:0]      code;
  logic [7:0]      sh_next, rx_next;

  assign first_ph = first_from(PH_CMD, cnt);
  assign after_ph = first_from(ph + 3'd1, cnt);
  assign code     = lc[ph];

  always_comb begin
    case (code)
      2'd0: begin
        sh_next = {sh[6:0], 1'b0};
        rx_next = {rx[6:0], io_in[1]};
        io_out  = {3'b000, sh[7]};
      end
      2'd1: begin
        sh_next = {sh[5:0], 2'b00};
        rx_next = {rx[5:0], io_in[1:0]};
        io_out  = {2'b00, sh[7:6]};
      end
      default: begin
        sh_next = {sh[3:0], 4'h0};
        rx_next = {rx[3:0], io_in};
        io_out  = sh[7:4];
      end
    endcase
    io_oe = (busy && (ph == PH_CMD || ph == PH_ADR || ph == PH_WR)) ? lane_mask(code) : 4'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cs_on <= 1'b0; cs_q <= '0; ph <= PH_END;
      bidx <= '0; left <= '0; sh <= '0; rx <= '0; sck <= 1'b0;
      div <= '0; fin <= 1'b0; rx_bytes <= '0;
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        if (rel) cs_on <= 1'b0;
        if (launch) begin
          sck <= 1'b0;
          div <= '0;
          if (first_ph == PH_END) begin
            fin <= 1'b1;
          end else begin
            cs_on <= 1'b1;
            cs_q  <= sel;
            busy  <= 1'b1;
            ph    <= first_ph;
            bidx  <= '0;
            sh    <= byte_sel(first_ph, 5'd0);
            left  <= byte_clks_m1(lc[first_ph]);
          end
        end
      end else if (div != DIV_END) begin
        div <= div + 1'b1;
      end else begin
        div <= '0;
        if (!sck) begin
          sck <= 1'b1;
          if (ph == PH_RD) rx <= rx_next;
        end else begin
          sck <= 1'b0;
          if (left != 3'd0) begin
            left <= left - 3'd1;
            sh   <= sh_next;
          end else begin
            if (ph == PH_RD) rx_bytes[{bidx, 3'b000} +: 8] <= rx;
            if (bidx + 5'd1 < cnt[ph]) begin
              bidx <= bidx + 5'd1;
              sh   <= byte_sel(ph, bidx + 5'd1);
              left <= byte_clks_m1(code);
            end else if (after_ph == PH_END) begin
              busy <= 1'b0;
              fin  <= 1'b1;
              ph   <= PH_END;
            end else begin
              ph   <= after_ph;
              bidx <= '0;
              sh   <= byte_sel(after_ph, 5'd0);
              left <= byte_clks_m1(lc[after_ph]);
            end
          end
        end
      end
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = !(cs_on && cs_q == SELW'(i));
  end
endmodule

// File: rtl/fsx_flash_engine.sv
module fsx_flash_engine #(
  parameter int NCS      = 4,
  parameter int MAXB     = 16,
  parameter int HALF_DIV = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           sck,
  output logic [NCS-1:0] cs_n,
  output logic [3:0]     io_out,
  output logic [3:0]     io_oe,
  input  logic [3:0]     io_in
);
  localparam int SELW = (NCS > 1) ? $clog2(NCS) : 1;

  logic [31:0]       cfg_q, adr_q;
  logic [7:0]        cmd_q;
  logic [8*MAXB-1:0] wbytes, rx_bytes;
  logic [SELW-1:0]   sel_q;
  logic              rel_q, launch, fin;

  fsx_regs #(.MAXB(MAXB), .SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fin(fin), .rx_bytes(rx_bytes),
    .cfg_q(cfg_q), .cmd_q(cmd_q), .adr_q(adr_q), .wbytes(wbytes),
    .sel_q(sel_q), .rel_q(rel_q), .launch(launch)
  );

  fsx_seq #(.NCS(NCS), .MAXB(MAXB), .HALF_DIV(HALF_DIV), .SELW(SELW)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cfg(cfg_q), .cmd(cmd_q),
    .adr(adr_q), .wbytes(wbytes), .sel(sel_q), .rel(rel_q), .io_in(io_in),
    .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .fin(fin),
    .rx_bytes(rx_bytes)
  );
endmodule

// File: rtl/fsx_chk.sv
module fsx_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sck,
  input logic [NCS-1:0] cs_n,
  input logic [3:0]     io_out,
  input logic [3:0]     io_oe
);
  a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r7_out_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> ($stable(io_out) && $stable(io_oe)));

  a_r7_clock_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !(&cs_n));

  a_r9_select_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != $past(cs_n)) |-> (!sck && !$past(sck)));

  a_r4_enable_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'h0 || io_oe == 4'h1 || io_oe == 4'h3 || io_oe == 4'hF));
endmodule

bind fsx_flash_engine fsx_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe)
);

// File: tb/tb_fsx_flash_engine.sv
module tb_fsx_flash_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        sck;
  logic [3:0]  cs_n;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = 4'h0;

  int checks = 0;
  int fails  = 0;

  logic [3:0] exp_out [512];
  logic [3:0] exp_oe  [512];
  logic [3:0] drv     [512];
  logic [3:0] cap_out [512];
  logic [3:0] cap_oe  [512];
  logic [3:0] cap_cs  [512];
  time        cap_t   [512];
  int         n_exp;
  int         ecount = 0;
  logic [7:0] wbuf [16];
  logic [7:0] rexp [16];

  fsx_flash_engine dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  always #4 clk = ~clk;

  // flash-side model: capture at rising edge, change input after falling edge
  always @(posedge sck) begin
    if (ecount < 512) begin
      cap_out[ecount] = io_out;
      cap_oe[ecount]  = io_oe;
      cap_cs[ecount]  = cs_n;
      cap_t[ecount]   = $time;
    end
    ecount++;
  end
  always @(negedge sck) if (ecount < 512) io_in = drv[ecount];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    int polls = 0;
    rd(8'h0C, v);
    while (v[0] && polls < 3000) begin
      rd(8'h0C, v);
      polls++;
    end
    check(!v[0], req, v, 32'h0);
  endtask

  task automatic add_byte(input logic [7:0] b, input logic [1:0] code, input int kind);
    int w;
    logic [3:0] nib, mask;
    logic [7:0] s;
    w    = (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
    mask = (w == 1) ? 4'h1 : (w == 2) ? 4'h3 : 4'hF;
    for (int k = 0; k < 8 / w; k++) begin
      s   = b << (w * k);
      nib = (w == 1) ? {3'b000, s[7]} : (w == 2) ? {2'b00, s[7:6]} : s[7:4];
      exp_out[n_exp] = (kind == 0) ? nib : 4'h0;
      exp_oe[n_exp]  = (kind == 0) ? mask : 4'h0;
      drv[n_exp]     = (kind == 2) ? ((w == 1) ? {2'b00, s[7], 1'b0} : nib) : 4'h0;
      n_exp++;
    end
  endtask

  // program, launch, wait, compare wire activity and read words
  task automatic do_xact(input logic [31:0] cfgv, input logic [7:0] cmdv,
                         input logic [31:0] adrv, input logic [31:0] ctlv,
                         input int sel, input string req);
    int na, nd, nw, nr, bad;
    logic [31:0] v;
    n_exp = 0;
    na = (cfgv[13:11] > 4) ? 4 : int'(cfgv[13:11]);
    nd = int'(cfgv[23:21]);
    nw = (cfgv[20:16] > 16) ? 16 : int'(cfgv[20:16]);
    nr = (cfgv[28:24] > 16) ? 16 : int'(cfgv[28:24]);
    if (cfgv[10]) add_byte(cmdv, cfgv[1:0], 0);
    for (int i = 0; i < na; i++) add_byte(8'(adrv >> (8 * (na - 1 - i))), cfgv[3:2], 0);
    for (int i = 0; i < nd; i++) add_byte(8'h00, cfgv[7:6], 1);
    for (int i = 0; i < nw; i++) add_byte(wbuf[i], cfgv[5:4], 0);
    for (int i = 0; i < nr; i++) add_byte(rexp[i], cfgv[9:8], 2);
    wr(8'h08, cfgv);
    wr(8'h10, {24'd0, cmdv});
    wr(8'h14, adrv);
    for (int w = 0; w < 4; w++)
      wr(8'h20 + 8'(4 * w), {wbuf[4*w+3], wbuf[4*w+2], wbuf[4*w+1], wbuf[4*w]});
    ecount = 0;
    io_in  = drv[0];
    wr(8'h0C, ctlv | 32'h1);
    wait_done(req);
    check(ecount == n_exp, {req, " edge count"}, 32'(ecount), 32'(n_exp));
    bad = 0;
    for (int e = 0; e < n_exp && e < 512; e++) begin
      if (cap_oe[e] !== exp_oe[e]) bad++;
      else if (exp_oe[e] != 4'h0 && (cap_out[e] & exp_oe[e]) !== exp_out[e]) bad++;
    end
    check(bad == 0, {req, " line pattern"}, 32'(bad), 32'h0);
    if (n_exp > 0)
      check(cap_cs[0] == ~(4'b0001 << sel) && cap_cs[n_exp-1] == cap_cs[0],
            {req, " R8 select"}, {28'd0, cap_cs[0]}, {28'd0, ~(4'b0001 << sel)});
    for (int w = 0; w < 4; w++) begin
      if (4 * w < nr) begin
        rd(8'h30 + 8'(4 * w), v);
        bad = 0;
        for (int b = 0; b < 4; b++)
          if (4 * w + b < nr && v[8*b +: 8] !== rexp[4*w+b]) bad++;
        check(bad == 0, {req, " R6 read word"}, v,
              {rexp[4*w+3], rexp[4*w+2], rexp[4*w+1], rexp[4*w]});
      end
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h0C, v);
    check(v == 32'h0001_0000, "R1 control reset", v, 32'h0001_0000);
    rd(8'h08, v);
    check(v == 32'h0, "R1 layout reset", v, 32'h0);
    check(cs_n == 4'hF && sck == 1'b0, "R1 pins reset", {27'd0, sck, cs_n}, 32'hF);
  endtask

  task automatic t_single_read;
    logic [31:0] v;
    for (int i = 0; i < 16; i++) wbuf[i] = 8'h00;
    rexp[0] = 8'hEF; rexp[1] = 8'h40; rexp[2] = 8'h18;
    n_exp = 0;
    // R3 R4: opcode then three one-line read bytes
    do_xact((32'd1 << 10) | (32'd3 << 24), 8'h9F, 32'h0, 32'h0001_0000, 0, "R3 R4 single read");
    check(cap_t[1] - cap_t[0] == 32, "R7 clock period", 32'(cap_t[1] - cap_t[0]), 32);
    check(sck == 1'b0 && cs_n == 4'hF, "R7 idle after", {27'd0, sck, cs_n}, 32'hF);
    // R2: bit 0 reads 1 while running
    wr(8'h0C, 32'h0001_0001);
    rd(8'h0C, v);
    check(v[0] == 1'b1, "R2 running flag", v, 32'h1);
    wait_done("R2 clear");
  endtask

  task automatic t_quad_read;
    for (int i = 0; i < 16; i++) rexp[i] = 8'(i * 17 + 3);
    // R5 R13: 3 address bytes, 2 dummy bytes, 16 read bytes, all four lines
    do_xact((32'd2 << 2) | (32'd2 << 6) | (32'd2 << 8) | (32'd1 << 10) | (32'd3 << 11) |
            (32'd2 << 21) | (32'd16 << 24), 8'hEB, 32'hA512_3456,
            32'h0001_0100, 1, "R5 R13 quad read");
  endtask

  task automatic t_dual_write;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h3C; wbuf[3] = 8'hC4; wbuf[4] = 8'h5A;
    // R6 R4: four address bytes and five data bytes on two lines
    do_xact((32'd1 << 2) | (32'd1 << 4) | (32'd1 << 10) | (32'd4 << 11) | (32'd5 << 16),
            8'h3B, 32'h89AB_CDEF, 32'h0001_0300, 3, "R6 R4 dual write");
    for (int i = 0; i < 16; i++) wbuf[i] = 8'h00;
  endtask

  task automatic t_empty;
    logic [31:0] v;
    wr(8'h08, 32'h0);
    ecount = 0;
    wr(8'h0C, 32'h0001_0001);
    wait_done("R12 empty finish");
    check(ecount == 0 && cs_n == 4'hF, "R12 no activity", 32'(ecount), 32'h0);
    rd(8'h0C, v);
    check(v[24] == 1'b1, "R10 ready set", v, 32'h0100_0000);
    wr(8'h0C, 32'h0301_0000);
    rd(8'h0C, v);
    check(v == 32'h0201_0000, "R10 ready clear enable kept", v, 32'h0201_0000);
  endtask

  task automatic t_hold;
    rexp[0] = 8'h5A;
    do_xact(32'd1 << 10, 8'h06, 32'h0, 32'h0000_0200, 2, "R9 held opcode");
    repeat (4) @(negedge clk);
    check(cs_n == 4'b1011, "R9 select held", {28'd0, cs_n}, 32'hB);
    do_xact((32'd1 << 10) | (32'd1 << 24), 8'h05, 32'h0, 32'h0001_0200, 2, "R9 second part");
    repeat (4) @(negedge clk);
    check(cs_n == 4'hF, "R9 select released", {28'd0, cs_n}, 32'hF);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v;
    logic [31:0] c0;
    c0 = (32'd1 << 10) | (32'd2 << 24);
    wr(8'h08, c0);
    wr(8'h10, 32'h0B);
    wr(8'h0C, 32'h0001_0001);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h10, 32'h77);
    wr(8'h0C, 32'h0000_0300);
    wait_done("R11 finish");
    rd(8'h08, v);
    check(v == c0, "R11 layout kept", v, c0);
    rd(8'h10, v);
    check(v == 32'h0B, "R11 opcode kept", v, 32'h0B);
    rd(8'h0C, v);
    check((v & 32'h0001_0300) == 32'h0001_0000, "R11 select fields kept", v, 32'h0001_0000);
    check(cs_n == 4'hF, "R11 select released", {28'd0, cs_n}, 32'hF);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      drv[i] = 4'h0; exp_out[i] = 4'h0; exp_oe[i] = 4'h0;
      cap_out[i] = 4'h0; cap_oe[i] = 4'h0; cap_cs[i] = 4'hF; cap_t[i] = 0;
    end
    for (int i = 0; i < 16; i++) begin
      wbuf[i] = 8'h00; rexp[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single_read();
    t_quad_read();
    t_dual_write();
    t_empty();
    t_hold();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule